// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This unit sits between the fault detectors of a processor core and the logic that enters exception handlers. Each request carries a vector number, an error code and a flag that marks a software-raised interrupt. For a hardware exception, the unit compares the new vector with the class of the exception that is still being delivered. From that comparison it decides what happens next. The original vector may go through unchanged. It may be promoted to a double fault (vector 8) with a zero error code. Or, when a double fault is already in progress, the unit drops the request and raises a one-cycle shutdown pulse, which signals a triple fault.

The unit keeps a small history register. The register records whether an exception is in flight and which class it belongs to: contributory, page fault or double fault. The handler-entry logic pulses a clear input once a handler has been entered successfully, and that empties the history. Software interrupts and vectors outside the architectural range skip the checks entirely. All results are registered and come out one clock after the request, marked by a valid output.

Top module: `exc_escalate`

## Requirements
- R1: While reset is high, and in the first cycle after reset, out_vld and out_shutdown are 0 and the history is empty.
- R2: A request presented in cycle n gives its result in cycle n+1. In any cycle with no request in the previous cycle, out_vld and out_shutdown are 0.
- R3: Contributory vectors are 0, 10, 11, 12 and 13. A hardware request with a contributory vector, arriving while the history holds a contributory class, is delivered as vector 8 with error code 0.
- R4: A hardware request with a contributory vector or vector 14, arriving while the history holds a page fault (vector 14), is delivered as vector 8 with error code 0.
- R5: A hardware in-range request, arriving while the history holds a double fault, gives out_shutdown=1 for one cycle and out_vld=0, and it empties the history.
- R6: A hardware request that does not escalate is delivered with its own vector and error code. Examples are any request when the history is empty, a page fault after a contributory class, and a benign vector after any class.
- R7: The history is loaded only when the delivered vector is contributory, 14 or 8. A benign vector (for example 2 or 3) leaves it unchanged.
- R8: A request with the software flag set is delivered unchanged and leaves the history unchanged.
- R9: A vector of 32 or more is delivered unchanged and leaves the history unchanged.
- R10: clr_hist empties the history at the next edge. It takes priority over a history load from a request in the same cycle, and that request is still classified against the old history.
- R11: When the history is empty, no request escalates or triggers shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_vec | input | VEC_W | Requested vector |
| req_err | input | ERR_W | Requested error code |
| req_swint | input | 1 | Request is a software interrupt |
| clr_hist | input | 1 | Handler entered; empty the history |
| out_vld | output | 1 | Delivered vector valid |
| out_vec | output | VEC_W | Delivered vector |
| out_err | output | ERR_W | Delivered error code |
| out_shutdown | output | 1 | Triple-fault shutdown pulse |

## Verification
A wrong history value cannot be seen directly at the ports. It shows up only on the next hardware request, as an escalation that should not happen, a missing double fault, or a shutdown pulse where a vector was expected. Each directed sequence therefore follows a state-changing request with a probe vector whose result depends on the history, so that a bad update becomes visible one cycle after the probe. A long random stream mixes contributory, page-fault, benign, out-of-range, software and clear stimuli against a behavioural model to reach the less common orderings.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;
  typedef enum logic [1:0] {
    CLS_BENIGN  = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2,
    CLS_DOUBLE  = 2'd3
  } exc_cls_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_esc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int ARCH_VECS  = 32,
  parameter int DF_VEC     = 8,
  parameter int PF_VEC     = 14,
  parameter int CONTRIB_LO = 10,
  parameter int CONTRIB_HI = 13
) (
  input  logic [VEC_W-1:0] vec,
  output logic             in_range,
  output exc_cls_e         cls
);
  localparam logic [VEC_W-1:0] LIMIT = VEC_W'(ARCH_VECS);
  localparam logic [VEC_W-1:0] DF    = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] PF    = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] C_LO  = VEC_W'(CONTRIB_LO);
  localparam logic [VEC_W-1:0] C_HI  = VEC_W'(CONTRIB_HI);

  always_comb begin
    in_range = (vec < LIMIT);
    if (vec == '0 || (vec >= C_LO && vec <= C_HI)) cls = CLS_CONTRIB;
    else if (vec == PF)                             cls = CLS_PAGE;
    else if (vec == DF)                             cls = CLS_DOUBLE;
    else                                            cls = CLS_BENIGN;
  end
endmodule

// File: rtl/exc_resolve.sv
module exc_resolve
  import exc_esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int DF_VEC = 8
) (
  input  logic             hist_vld,
  input  exc_cls_e         hist_cls,
  input  exc_cls_e         new_cls,
  input  logic             in_range,
  input  logic             swint,
  input  logic [VEC_W-1:0] vec,
  input  logic [ERR_W-1:0] err,
  output logic [VEC_W-1:0] res_vec,
  output logic [ERR_W-1:0] res_err,
  output exc_cls_e         res_cls,
  output logic             triple,
  output logic             load_hist
);
  localparam logic [VEC_W-1:0] DF = VEC_W'(DF_VEC);

  logic bypass, pair_cc, pair_pf, escalate;

  always_comb begin
    bypass   = swint || !in_range;
    triple   = !bypass && hist_vld && (hist_cls == CLS_DOUBLE);
    pair_cc  = (hist_cls == CLS_CONTRIB) && (new_cls == CLS_CONTRIB);
    pair_pf  = (hist_cls == CLS_PAGE) &&
               (new_cls == CLS_CONTRIB || new_cls == CLS_PAGE);
    escalate = !bypass && hist_vld && (pair_cc || pair_pf);
    res_vec  = escalate ? DF : vec;
    res_err  = escalate ? '0 : err;
    res_cls  = escalate ? CLS_DOUBLE : new_cls;
    load_hist = !bypass && !triple && (res_cls != CLS_BENIGN);
  end
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_esc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int ERR_W      = 32,
  parameter int ARCH_VECS  = 32,
  parameter int DF_VEC     = 8,
  parameter int PF_VEC     = 14,
  parameter int CONTRIB_LO = 10,
  parameter int CONTRIB_HI = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [ERR_W-1:0] req_err,
  input  logic             req_swint,
  input  logic             clr_hist,
  output logic             out_vld,
  output logic [VEC_W-1:0] out_vec,
  output logic [ERR_W-1:0] out_err,
  output logic             out_shutdown
);
  logic             hist_vld;
  exc_cls_e         hist_cls;
  logic             in_range;
  exc_cls_e         new_cls;
  logic [VEC_W-1:0] res_vec;
  logic [ERR_W-1:0] res_err;
  exc_cls_e         res_cls;
  logic             triple, load_hist;

  exc_classify #(
    .VEC_W(VEC_W), .ARCH_VECS(ARCH_VECS), .DF_VEC(DF_VEC), .PF_VEC(PF_VEC),
    .CONTRIB_LO(CONTRIB_LO), .CONTRIB_HI(CONTRIB_HI)
  ) u_cls (
    .vec(req_vec), .in_range(in_range), .cls(new_cls)
  );

  exc_resolve #(
    .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)
  ) u_res (
    .hist_vld(hist_vld), .hist_cls(hist_cls), .new_cls(new_cls),
    .in_range(in_range), .swint(req_swint), .vec(req_vec), .err(req_err),
    .res_vec(res_vec), .res_err(res_err), .res_cls(res_cls),
    .triple(triple), .load_hist(load_hist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld      <= 1'b0;
      out_shutdown <= 1'b0;
      out_vec      <= '0;
      out_err      <= '0;
    end else begin
      out_vld      <= req_vld && !triple;
      out_shutdown <= req_vld && triple;
      if (req_vld) begin
        out_vec <= res_vec;
        out_err <= res_err;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_vld <= 1'b0;
      hist_cls <= CLS_BENIGN;
    end else if (clr_hist || (req_vld && triple)) begin
      hist_vld <= 1'b0;
    end else if (req_vld && load_hist) begin
      hist_vld <= 1'b1;
      hist_cls <= res_cls;
    end
  end
endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk #(
  parameter int VEC_W     = 8,
  parameter int ERR_W     = 32,
  parameter int ARCH_VECS = 32,
  parameter int DF_VEC    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_vld,
  input logic [VEC_W-1:0] req_vec,
  input logic [ERR_W-1:0] req_err,
  input logic             req_swint,
  input logic             out_vld,
  input logic [VEC_W-1:0] out_vec,
  input logic [ERR_W-1:0] out_err,
  input logic             out_shutdown
);
  localparam logic [VEC_W-1:0] DF    = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] LIMIT = VEC_W'(ARCH_VECS);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_vld) |-> (!out_vld && !out_shutdown));

  // R5
  vld_xor_sd_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_vld && out_shutdown));

  // R5
  sd_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_shutdown |=> !out_shutdown);

  // R8
  swint_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(req_vld && req_swint) |->
      (out_vld && out_vec == $past(req_vec) && out_err == $past(req_err)));

  // R9
  range_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(req_vld && !req_swint && (req_vec >= LIMIT)) |->
      (out_vld && out_vec == $past(req_vec) && out_err == $past(req_err)));

  // R3
  df_zero_err_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_vec == DF && $past(req_vec) != DF) |-> (out_err == '0));
endmodule

bind exc_escalate exc_escalate_chk #(
  .VEC_W(VEC_W), .ERR_W(ERR_W), .ARCH_VECS(ARCH_VECS), .DF_VEC(DF_VEC)
) u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .req_vec(req_vec),
  .req_err(req_err), .req_swint(req_swint), .out_vld(out_vld),
  .out_vec(out_vec), .out_err(out_err), .out_shutdown(out_shutdown)
);

// File: tb/exc_escalate_bench.sv
module exc_escalate_bench;
  localparam int CLK_P = 10;
  localparam int VW = 8;
  localparam int EW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_vld = 1'b0;
  logic [VW-1:0] req_vec = '0;
  logic [EW-1:0] req_err = '0;
  logic          req_swint = 1'b0;
  logic          clr_hist = 1'b0;
  logic          out_vld, out_shutdown;
  logic [VW-1:0] out_vec;
  logic [EW-1:0] out_err;

  int checks = 0;
  int bad = 0;

  // behavioural reference state
  bit          m_hv = 0;
  int          m_hist = 0;
  bit          e_vld, e_sd;
  int          e_vec;
  logic [EW-1:0] e_err;

  always #(CLK_P/2) clk = ~clk;

  exc_escalate u_exc_escalate (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_vec(req_vec),
    .req_err(req_err), .req_swint(req_swint), .clr_hist(clr_hist),
    .out_vld(out_vld), .out_vec(out_vec), .out_err(out_err),
    .out_shutdown(out_shutdown)
  );

  function automatic bit is_contrib(int v);
    return v == 0 || (v >= 10 && v <= 13);
  endfunction

  task automatic model(bit v, int vec, logic [EW-1:0] e, bit sw, bit clr);
    bit esc;
    int r;
    e_vld = 0; e_sd = 0; e_vec = 0; e_err = '0;
    if (v) begin
      if (sw || vec >= 32) begin
        e_vld = 1; e_vec = vec; e_err = e;
      end else if (m_hv && m_hist == 8) begin
        e_sd = 1; m_hv = 0;
      end else begin
        esc = m_hv && ((is_contrib(m_hist) && is_contrib(vec)) ||
                       (m_hist == 14 && (is_contrib(vec) || vec == 14)));
        r = esc ? 8 : vec;
        e_vld = 1; e_vec = r; e_err = esc ? '0 : e;
        if (is_contrib(r) || r == 14 || r == 8) begin
          m_hv = 1; m_hist = r;
        end
      end
    end
    if (clr) m_hv = 0;
  endtask

  task automatic step(bit v, int vec, logic [EW-1:0] e, bit sw, bit clr, string tag);
    @(negedge clk);
    req_vld = v; req_vec = VW'(vec); req_err = e; req_swint = sw; clr_hist = clr;
    model(v, vec, e, sw, clr);
    @(posedge clk);
    #(CLK_P/4);
    req_vld = 0; req_swint = 0; clr_hist = 0;
    checks++;
    if (out_vld !== e_vld || out_shutdown !== e_sd ||
        (e_vld && (out_vec !== VW'(e_vec) || out_err !== e_err))) begin
      bad++;
      $display("FAIL %s: got vld=%0b sd=%0b vec=%0d err=%0h, expected vld=%0b sd=%0b vec=%0d err=%0h",
               tag, out_vld, out_shutdown, out_vec, out_err, e_vld, e_sd, e_vec, e_err);
    end
  endtask

  function automatic logic [EW-1:0] ec(int k);
    return EW'(32'hA500 + k);
  endfunction

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL R2 watchdog: got no finish, expected finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int pool [10] = '{0, 8, 10, 11, 12, 13, 14, 2, 3, 40};
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_shutdown !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: got vld=%0b sd=%0b, expected 0 0", out_vld, out_shutdown);
    end
    rst = 1'b0;
    step(0, 0, '0, 0, 0, "R1 post-reset idle");
    step(0, 0, '0, 0, 0, "R2 idle");
    // R11 empty history: first contributory passes, then pairing escalates
    step(1, 13, ec(1), 0, 0, "R11 empty history no escalation");
    step(1, 10, ec(2), 0, 0, "R3 contrib after contrib");
    step(1, 3, ec(3), 0, 0, "R5 fault during double -> shutdown");
    step(1, 14, ec(4), 0, 0, "R5 history emptied by shutdown");
    step(1, 14, ec(5), 0, 0, "R4 page after page");
    step(1, 0, ec(6), 0, 0, "R5 vector 0 during double");
    step(0, 0, '0, 0, 0, "R2 idle after shutdown");
    step(1, 0, ec(7), 0, 0, "R6 vector 0 with empty history");
    step(1, 14, ec(8), 0, 0, "R6 page after contrib not escalated");
    step(1, 2, ec(9), 0, 0, "R7 benign delivered");
    step(1, 12, ec(10), 0, 0, "R7 benign left page history; R4 contrib after page");
    step(0, 0, '0, 0, 1, "R10 clear");
    step(1, 13, ec(11), 0, 0, "R10 cleared history");
    step(1, 11, ec(12), 0, 0, "R3 contrib pair");
    step(0, 0, '0, 0, 1, "R10 clear");
    step(1, 11, ec(13), 0, 0, "R11 after clear");
    step(1, 12, ec(14), 0, 1, "R10 same-cycle req uses old history");
    step(1, 12, ec(15), 0, 0, "R10 clear beats load");
    step(0, 0, '0, 0, 1, "R10 clear");
    step(1, 13, ec(16), 1, 0, "R8 software interrupt passes");
    step(1, 10, ec(17), 0, 0, "R8 software left history empty");
    step(1, 12, ec(18), 1, 0, "R8 software not escalated");
    step(0, 0, '0, 0, 1, "R10 clear");
    step(1, 40, ec(19), 0, 0, "R9 out of range passes");
    step(1, 10, ec(20), 0, 0, "R9 history not loaded");
    step(1, 200, ec(21), 0, 0, "R9 out of range not escalated");
    step(1, 11, ec(22), 0, 0, "R3 history still contrib");
    step(1, 32, ec(23), 0, 0, "R9 boundary 32 during double");
    step(1, 31, ec(24), 0, 0, "R5 boundary 31 during double");
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 99));
      int v = pool[$urandom_range(0, 9)];
      step(r < 85, v, EW'($urandom), r < 8, r >= 90, "R6 random stream");
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule